// File: doc/BRIEF.md
# Tributary Path Error Counter Pair

This block keeps the performance-monitoring error counts of one low-order tributary path. Once per multiframe a strobe arrives with two pieces of information taken from the path overhead byte: the number of path parity errors found in the previous frame (0, 1 or 2, as computed upstream) and the remote error indication bit. A 12-bit running counter accumulates parity errors and an 11-bit running counter accumulates remote error indications.

A periodic performance-monitoring tick moves both running counts into holding registers, which the processor reads at its leisure, and restarts the running counts. A select input chooses whether the running counters clamp at all-ones or wrap around. While the path is in a defect state (loss of pointer, tributary AIS, loss of multiframe alignment, or a request for automatic AIS insertion) both running counts and both holding registers are held at zero.

Internally a two-state controller tracks the defect condition. Its states are `ST_COUNTING` (no defect) and `ST_SQUELCHED` (some defect present). Its transitions are `squelch_enter` (`ST_COUNTING` to `ST_SQUELCHED` when any defect is sampled) and `squelch_exit` (`ST_SQUELCHED` to `ST_COUNTING` when all defects are clear). Each cycle the top module selects one counter operation, in priority order: `OP_CLEAR`, `OP_XFER`, `OP_ACCUM`.

Top module: `trib_err_pair`

## Requirements
- R1: On a cycle with `frame_stb`=1 the parity running count grows by `par_err` (0, 1 or 2). The code 3 counts as 2. With `frame_stb`=0 it grows by nothing.
- R2: On a cycle with `frame_stb`=1 and `rei_bit`=1 the remote-error running count grows by 1. Otherwise it grows by nothing.
- R3: When `pm_tick`=1 and no defect is present, each holding register takes the running value from before the edge. Each running count restarts at that cycle's increment, which is 0 when there is no strobe.
- R4: With `sat_sel`=1 a running count never passes all-ones. For example, parity 4094 plus 2 gives 4095, and 4095 plus 2 stays 4095.
- R5: With `sat_sel`=0 a running count wraps modulo 2^width. For example, parity 4095 plus 2 gives 1, and remote-error count 2047 plus 1 gives 0.
- R6: While any of `lop_in`, `ais_in`, `lom_in` or `auto_ais_in` is 1, all four counts are zero after the edge. This takes priority over the tick and over any increment.
- R7: A holding register changes only on a transfer or under a defect. Increments leave it as it was.
- R8: After reset all four counts read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe, once per multiframe |
| par_err | input | 2 | Parity errors found in the frame (0..2; 3 treated as 2) |
| rei_bit | input | 1 | Remote error indication bit of the overhead byte |
| pm_tick | input | 1 | Performance-monitoring transfer pulse |
| sat_sel | input | 1 | 1: clamp at all-ones, 0: wrap |
| lop_in | input | 1 | Loss of pointer defect |
| ais_in | input | 1 | Tributary AIS defect |
| lom_in | input | 1 | Loss of multiframe alignment defect |
| auto_ais_in | input | 1 | Automatic AIS request |
| par_run | output | 12 | Parity running count |
| par_hold | output | 12 | Parity holding register |
| rei_run | output | 11 | Remote-error running count |
| rei_hold | output | 11 | Remote-error holding register |

## Verification
The bench drives the parity counter up to its top value with double increments. This exposes a clamp that wraps when the sum carries past the width, and a wrap mode that stops at the top or lands on 0 instead of 1. It issues transfer ticks in the same cycle as errors: a design that dropped the new frame's increment, or that copied the post-increment value into the holding register, would be off by that increment. It raises each defect input alone together with a tick and errors, which catches a defect that does not win over the transfer or that clears only the running counts. Random traffic with strobes missing then shows whether counts move without a strobe or whether holding registers drift.

// File: rtl/trib_pm_pkg.sv
package trib_pm_pkg;

    // Defect-tracking controller states
    typedef enum logic {
        ST_COUNTING  = 1'b0,
        ST_SQUELCHED = 1'b1
    } squelch_state_e;

    // Per-cycle operation applied to a counter/holding pair
    typedef enum logic [1:0] {
        OP_ACCUM = 2'd0,
        OP_XFER  = 2'd1,
        OP_CLEAR = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/trib_v5_incr.sv
module trib_v5_incr #(
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [1:0]       par_err,
    input  logic             rei_bit,
    output logic [INC_W-1:0] par_inc,
    output logic [INC_W-1:0] rei_inc
);

    localparam logic [INC_W-1:0] INC_TWO = INC_W'(2);
    localparam logic [INC_W-1:0] INC_ONE = INC_W'(1);

    // Parity errors per frame are limited to the two parity bits
    always_comb begin
        par_inc = '0;
        if (frame_stb) begin
            unique case (par_err)
                2'd0:    par_inc = '0;
                2'd1:    par_inc = INC_ONE;
                default: par_inc = INC_TWO;
            endcase
        end
    end

    always_comb begin
        rei_inc = '0;
        if (frame_stb && rei_bit) begin
            rei_inc = INC_ONE;
        end
    end

    AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_inc <= INC_TWO) && (rei_inc <= INC_ONE));  // R1

    AST_NO_STROBE_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> (par_inc == '0 && rei_inc == '0));  // R2

endmodule

// File: rtl/trib_defect_fsm.sv
module trib_defect_fsm
    import trib_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] defects,
    output logic       squelch,
    output logic       in_squelch
);

    squelch_state_e state_q, state_d;
    logic           any_defect;

    assign any_defect = |defects;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNTING:  if (any_defect)  state_d = ST_SQUELCHED;  // squelch_enter
            ST_SQUELCHED: if (!any_defect) state_d = ST_COUNTING;   // squelch_exit
            default:      state_d = ST_COUNTING;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNTING;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: forcing applies in the very cycle a defect is sampled
    always_comb begin
        in_squelch = (state_q == ST_SQUELCHED);
        squelch    = any_defect;
    end

    AST_SQUELCH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        any_defect |=> (state_q == ST_SQUELCHED));  // R6

    AST_SQUELCH_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_defect |=> (state_q == ST_COUNTING));  // R6

endmodule

// File: rtl/trib_sat_counter.sv
module trib_sat_counter
    import trib_pm_pkg::*;
#(
    parameter int W     = 12,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic             sat,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     run,
    output logic [W-1:0]     hold
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam int           PAD_W    = W + 1 - INC_W;

    logic [W-1:0] run_q, hold_q;
    logic [W-1:0] base;
    logic [W:0]   sum_ext;
    logic [W-1:0] run_next;

    // A transfer restarts the count, so the addition starts from zero
    always_comb begin
        base     = (op == OP_XFER) ? '0 : run_q;
        sum_ext  = {1'b0, base} + {{PAD_W{1'b0}}, inc};
        run_next = (sat && sum_ext[W]) ? ALL_ONES : sum_ext[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: begin
                    run_q  <= '0;
                    hold_q <= '0;
                end
                OP_XFER: begin
                    hold_q <= run_q;
                    run_q  <= run_next;
                end
                default: begin
                    run_q  <= run_next;
                end
            endcase
        end
    end

    assign run  = run_q;
    assign hold = hold_q;

    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (run_q == '0 && hold_q == '0));  // R6

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_XFER) |=> (hold_q == $past(run_q)));  // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCUM && sat) |=> (run_q >= $past(run_q)));  // R4

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCUM && !sat && run_q == ALL_ONES && inc != '0) |=> (run_q < $past(run_q)));  // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCUM) |=> $stable(hold_q));  // R7

endmodule

// File: rtl/trib_err_pair.sv
module trib_err_pair
    import trib_pm_pkg::*;
#(
    parameter int PAR_W = 12,
    parameter int REI_W = 11,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [1:0]       par_err,
    input  logic             rei_bit,
    input  logic             pm_tick,
    input  logic             sat_sel,
    input  logic             lop_in,
    input  logic             ais_in,
    input  logic             lom_in,
    input  logic             auto_ais_in,
    output logic [PAR_W-1:0] par_run,
    output logic [PAR_W-1:0] par_hold,
    output logic [REI_W-1:0] rei_run,
    output logic [REI_W-1:0] rei_hold
);

    localparam int N_CNT = 2;

    logic [INC_W-1:0] par_inc, rei_inc;
    logic             squelch, in_squelch;
    cnt_op_e          op;

    trib_v5_incr #(.INC_W(INC_W)) u_incr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .par_err   (par_err),
        .rei_bit   (rei_bit),
        .par_inc   (par_inc),
        .rei_inc   (rei_inc)
    );

    trib_defect_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .defects    ({auto_ais_in, lom_in, ais_in, lop_in}),
        .squelch    (squelch),
        .in_squelch (in_squelch)
    );

    // Priority: defect clear, then transfer, then accumulate
    always_comb begin
        unique case ({squelch, pm_tick})
            2'b10, 2'b11: op = OP_CLEAR;
            2'b01:        op = OP_XFER;
            default:      op = OP_ACCUM;
        endcase
    end

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            if (g == 0) begin : g_par
                trib_sat_counter #(.W(PAR_W), .INC_W(INC_W)) u_cnt (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .op    (op),
                    .sat   (sat_sel),
                    .inc   (par_inc),
                    .run   (par_run),
                    .hold  (par_hold)
                );
            end else begin : g_rei
                trib_sat_counter #(.W(REI_W), .INC_W(INC_W)) u_cnt (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .op    (op),
                    .sat   (sat_sel),
                    .inc   (rei_inc),
                    .run   (rei_run),
                    .hold  (rei_hold)
                );
            end
        end
    endgenerate

    AST_SQUELCHED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_squelch |-> (par_run == '0 && par_hold == '0 && rei_run == '0 && rei_hold == '0));  // R6

    AST_NO_STB_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !pm_tick && !squelch) |=> ($stable(par_run) && $stable(rei_run)));  // R1

endmodule

// File: tb/test_trib_err_pair.sv
module test_trib_err_pair;

    localparam int PMAX = 4095;
    localparam int RMAX = 2047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [1:0]  par_err = 2'd0;
    logic        rei_bit = 1'b0;
    logic        pm_tick = 1'b0;
    logic        sat_sel = 1'b0;
    logic        lop_in = 1'b0;
    logic        ais_in = 1'b0;
    logic        lom_in = 1'b0;
    logic        auto_ais_in = 1'b0;
    logic [11:0] par_run, par_hold;
    logic [10:0] rei_run, rei_hold;

    int    n_chk = 0;
    int    n_bad = 0;
    int    ep = 0, er = 0, hp = 0, hr = 0;
    string tag = "R8";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    trib_err_pair i_trib_err_pair (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .par_err(par_err),
        .rei_bit(rei_bit), .pm_tick(pm_tick), .sat_sel(sat_sel),
        .lop_in(lop_in), .ais_in(ais_in), .lom_in(lom_in), .auto_ais_in(auto_ais_in),
        .par_run(par_run), .par_hold(par_hold), .rei_run(rei_run), .rei_hold(rei_hold)
    );

    function automatic int add_cnt(int a, int i, int mx, bit sat);
        int s = a + i;
        if (s > mx) s = sat ? mx : s - (mx + 1);
        return s;
    endfunction

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("par_run", int'(par_run), ep);
        check("par_hold", int'(par_hold), hp);
        check("rei_run", int'(rei_run), er);
        check("rei_hold", int'(rei_hold), hr);
    endtask

    // Drive inputs, let one edge pass, update the model, compare
    task automatic step(bit stb, int pe, bit rb, bit tick, bit sat, bit [3:0] dfx);
        int ip, ir;
        frame_stb = stb; par_err = 2'(pe); rei_bit = rb; pm_tick = tick; sat_sel = sat;
        {auto_ais_in, lom_in, ais_in, lop_in} = dfx;
        @(posedge clk);
        ip = stb ? ((pe >= 2) ? 2 : pe) : 0;
        ir = (stb && rb) ? 1 : 0;
        if (dfx != 4'd0) begin
            ep = 0; er = 0; hp = 0; hr = 0;
        end else if (tick) begin
            hp = ep; hr = er;
            ep = add_cnt(0, ip, PMAX, sat);
            er = add_cnt(0, ir, RMAX, sat);
        end else begin
            ep = add_cnt(ep, ip, PMAX, sat);
            er = add_cnt(er, ir, RMAX, sat);
        end
        #1;
        compare_all();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        tag = "R8";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R7: random frames, some without strobe, no ticks
        tag = "R1_R2_R7";
        for (int k = 0; k < 200; k++) begin
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), 1'b0, 1'b1, 4'd0);
        end

        // R3: ticks, some coincident with errors
        tag = "R3";
        step(1'b1, 2, 1'b1, 1'b1, 1'b1, 4'd0);
        step(1'b1, 1, 1'b0, 1'b0, 1'b1, 4'd0);
        step(1'b0, 2, 1'b1, 1'b1, 1'b1, 4'd0);
        for (int k = 0; k < 150; k++) begin
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0), 1'b1, 4'd0);
        end

        // R4: clamp with double increments near the top
        tag = "R4";
        step(1'b0, 0, 1'b0, 1'b1, 1'b1, 4'd0);
        for (int k = 0; k < 2100; k++) step(1'b1, 2, 1'b1, 1'b0, 1'b1, 4'd0);
        check("par_run at clamp", int'(par_run), PMAX);
        check("rei_run at clamp", int'(rei_run), RMAX);

        // R5: wrap; 4094 + 2 -> 0, then 4095 + 2 -> 1, 2047 + 1 -> 0
        tag = "R5";
        step(1'b0, 0, 1'b0, 1'b1, 1'b0, 4'd0);
        for (int k = 0; k < 2047; k++) step(1'b1, 2, 1'b1, 1'b0, 1'b0, 4'd0);
        step(1'b1, 2, 1'b1, 1'b0, 1'b0, 4'd0);
        check("par_run wrap even", int'(par_run), 0);
        check("rei_run wrap", int'(rei_run), 0);
        step(1'b0, 0, 1'b0, 1'b1, 1'b0, 4'd0);
        for (int k = 0; k < 2047; k++) step(1'b1, 2, 1'b0, 1'b0, 1'b0, 4'd0);
        step(1'b1, 1, 1'b0, 1'b0, 1'b0, 4'd0);
        step(1'b1, 2, 1'b0, 1'b0, 1'b0, 4'd0);
        check("par_run wrap odd", int'(par_run), 1);

        // R6: each defect alone, with tick and errors in the same cycle
        tag = "R6";
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 20; k++) step(1'b1, 2, 1'b1, (k == 10), 1'b1, 4'd0);
            step(1'b1, 2, 1'b1, 1'b1, 1'b1, 4'(1 << d));
            step(1'b1, 1, 1'b1, 1'b0, 1'b1, 4'(1 << d));
            step(1'b1, 2, 1'b1, 1'b0, 1'b1, 4'd0);
        end

        // R7: holding stays put across many increments
        tag = "R7";
        step(1'b1, 1, 1'b1, 1'b1, 1'b1, 4'd0);
        for (int k = 0; k < 30; k++) step(1'b1, 2, 1'b1, 1'b0, 1'b0, 4'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule